// File: doc/BRIEF.md
# Pixel Prefetch FIFO with Watermark Burst Requests

This block sits between a memory fetch engine and a display pipeline. It stores up to 32 words of 32-bit pixel data. When the stored count falls to a programmable low threshold, it asks a memory read port for a burst. The burst length comes from one of two policies. In fixed mode, every burst has the same length, set by the high threshold. In dynamic mode, the burst is sized to leave a set number of empty slots, two fewer than the high threshold. Only one request is outstanding at a time. The request is held until it is granted, and no new request is raised until every word of the granted burst has arrived.

The display side pops one word at a time. A pop while the buffer is empty is an underrun. It sets a sticky flag that stays set until software clears it, and the block stops presenting data as valid. Output stays invalid until the next frame sync pulse. That pulse discards everything stored, so the next frame starts from freshly fetched words.

The memory side works as follows. The block raises `fetchReq` together with a length on `fetchLen`. The memory returns one `fetchGrant` pulse. It then delivers exactly that many words, each marked by `fillValid`. The words may have gaps between them.

Top module: `pixel_prefetch_fifo`

## Requirements
- R1: During reset and on the first sample after it, `fetchReq`, `pixValid` and `underrunFlag` are 0.
- R2: With no burst outstanding, a request is raised one cycle after a cycle in which the stored count is at or below `lowMark`. When the buffer drains one word per cycle, the request therefore follows the cycle in which the count equals `lowMark` exactly.
- R3: `fetchReq` stays high with a stable `fetchLen` until `fetchGrant` is seen. It is never high from the grant until the last word of that burst has been received.
- R4: In fixed mode (`dynBurst`=0), `fetchLen` equals `highMark`.
- R5: In dynamic mode (`dynBurst`=1), `fetchLen` equals (32 + 2 − `highMark`) − stored count. This leaves `highMark`−2 empty slots when no pops occur. With `highMark`=4 and `lowMark`=8, draining one word per cycle gives a request at 8 stored words for 22 words.
- R6: Words leave in arrival order. While `pixValid`=1, `pixData` shows the oldest stored word, and a pop removes it. While `pixValid`=0, `pixData` is 0.
- R7: A pop while the buffer holds no word sets `underrunFlag` on the next cycle. The flag holds until `underrunClr`, and a new underrun wins over a clear in the same cycle.
- R8: After an underrun, `pixValid` stays 0 and pops remove nothing, even while words arrive. The next `frameSync` pulse discards all stored words and ends this state.
- R9: A `frameSync` pulse with no underrun pending changes neither the stored words nor `pixValid`.
- R10: A word that arrives while 32 words are stored is discarded. The stored count never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lowMark | input | 6 | Stored-count threshold that triggers a fetch |
| highMark | input | 6 | Fixed burst length; in dynamic mode, target empty slots plus 2 |
| dynBurst | input | 1 | 1 selects dynamic burst sizing, 0 fixed |
| fetchReq | output | 1 | Burst request to the memory read port |
| fetchLen | output | 6 | Words requested, valid while `fetchReq` is high |
| fetchGrant | input | 1 | Memory accepts the pending request |
| fillValid | input | 1 | A returned word is present on `fillData` |
| fillData | input | 32 | Returned pixel word |
| pixPop | input | 1 | Display consumes the word on `pixData` |
| pixValid | output | 1 | `pixData` holds a good word |
| pixData | output | 32 | Oldest stored word, or 0 when not valid |
| frameSync | input | 1 | Frame boundary pulse |
| underrunClr | input | 1 | Clears the sticky underrun flag |
| underrunFlag | output | 1 | Sticky underrun indication |

## Verification
The bench runs several segments. A quiet fill with no pops shows whether dynamic sizing stops at exactly `highMark`−2 empty slots. A steady one-per-cycle drain shows whether the request triggers at the exact low-mark count rather than one word early or late. Random pop rates and random memory latencies, in both burst modes, show whether order and burst lengths hold up when refill and consumption overlap.

Heavy popping combined with occasional frame pulses and flag clears separates correct underrun blanking and flush from a design that recovers too early or keeps stale words. A fixed burst longer than the free space, with the grant withheld, shows whether excess words are dropped or allowed to wrap over stored data.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Strobes from control to the storage datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } pfStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_FILL = 2'd2
  } fetchPhase_t;

endpackage

// File: rtl/pf_store.sv
module pf_store
  import pf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pfStrobes_t       strb,
  input  logic [WIDTH-1:0] wrWord,
  output logic [WIDTH-1:0] headWord,
  output logic [CW-1:0]    fillCount
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push && !strb.flush) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else if (strb.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  assign headWord = mem[rdPtr];

endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] lowMark,
  input  logic [CW-1:0] highMark,
  input  logic          dynBurst,
  input  logic          fetchGrant,
  input  logic          fillValid,
  input  logic          pixPop,
  input  logic          frameSync,
  input  logic          underrunClr,
  input  logic [CW-1:0] fillCount,
  output pfStrobes_t    strb,
  output logic          fetchReq,
  output logic [CW-1:0] fetchLen,
  output logic          burstActive,
  output logic          blanked,
  output logic          pixValid,
  output logic          underrunFlag
);

  fetchPhase_t phase;
  logic [CW-1:0] remain;
  logic [CW-1:0] keepTarget, dynLen, nextLen;
  logic underrunEv, wantFetch;

  // Dynamic target: fill until (highMark-2) slots stay empty.
  always_comb begin
    if (highMark < CW'(2))
      keepTarget = CW'(DEPTH);
    else if (highMark >= CW'(DEPTH + 2))
      keepTarget = '0;
    else
      keepTarget = CW'(DEPTH + 2) - highMark;
    dynLen  = (keepTarget > fillCount) ? keepTarget - fillCount : '0;
    nextLen = dynBurst ? dynLen : highMark;
  end

  assign wantFetch  = (phase == PH_IDLE) && (fillCount <= lowMark) && (nextLen != '0);
  assign underrunEv = pixPop && (fillCount == '0);

  assign strb.flush = frameSync && blanked;
  assign strb.pop   = pixPop && (fillCount != '0) && !blanked;
  assign strb.push  = (phase == PH_FILL) && fillValid &&
                      (fillCount < CW'(DEPTH)) && !strb.flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      remain   <= '0;
      fetchLen <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (wantFetch) begin
          phase    <= PH_WAIT;
          fetchLen <= nextLen;
        end
        PH_WAIT: if (fetchGrant) begin
          phase  <= PH_FILL;
          remain <= fetchLen;
        end
        PH_FILL: if (fillValid) begin
          remain <= remain - 1'b1;
          if (remain == CW'(1)) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blanked      <= 1'b0;
      underrunFlag <= 1'b0;
    end else begin
      if (underrunEv)      blanked <= 1'b1;
      else if (strb.flush) blanked <= 1'b0;
      if (underrunEv)       underrunFlag <= 1'b1;
      else if (underrunClr) underrunFlag <= 1'b0;
    end
  end

  assign fetchReq    = (phase == PH_WAIT);
  assign burstActive = (phase == PH_FILL);
  assign pixValid    = (fillCount != '0) && !blanked;

endmodule

// File: rtl/pixel_prefetch_fifo.sv
module pixel_prefetch_fifo
  import pf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CW-1:0]    lowMark,
  input  logic [CW-1:0]    highMark,
  input  logic             dynBurst,
  output logic             fetchReq,
  output logic [CW-1:0]    fetchLen,
  input  logic             fetchGrant,
  input  logic             fillValid,
  input  logic [WIDTH-1:0] fillData,
  input  logic             pixPop,
  output logic             pixValid,
  output logic [WIDTH-1:0] pixData,
  input  logic             frameSync,
  input  logic             underrunClr,
  output logic             underrunFlag
);

  pfStrobes_t strb;
  logic [CW-1:0] fillCount;
  logic [WIDTH-1:0] headWord;
  logic burstActive, blanked;

  pf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrWord(fillData),
    .headWord(headWord), .fillCount(fillCount)
  );

  pf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .lowMark(lowMark), .highMark(highMark),
    .dynBurst(dynBurst), .fetchGrant(fetchGrant), .fillValid(fillValid),
    .pixPop(pixPop), .frameSync(frameSync), .underrunClr(underrunClr),
    .fillCount(fillCount), .strb(strb), .fetchReq(fetchReq),
    .fetchLen(fetchLen), .burstActive(burstActive), .blanked(blanked),
    .pixValid(pixValid), .underrunFlag(underrunFlag)
  );

  assign pixData = pixValid ? headWord : '0;

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          fetchReq,
  input logic [CW-1:0] fetchLen,
  input logic          fetchGrant,
  input logic          burstActive,
  input logic          blanked,
  input logic          frameSync,
  input logic          pixPop,
  input logic          pixValid,
  input logic          underrunFlag,
  input logic          underrunClr,
  input logic [CW-1:0] fillCount
);

  // R3: a pending request is held with a stable length until granted
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchGrant |=> fetchReq && $stable(fetchLen));

  // R3: no second request while a burst is being received
  assert_single_burst_R3: assert property (@(posedge clk) disable iff (!rstN)
    burstActive |-> !fetchReq);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  assert_underrun_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    pixPop && fillCount == '0 |=> underrunFlag && !pixValid);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrunFlag && !underrunClr |=> underrunFlag);

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    blanked && frameSync && !pixPop |=> fillCount == '0);

  assert_valid_has_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> fillCount != '0);

endmodule

bind pixel_prefetch_fifo pf_checker #(.DEPTH(DEPTH)) u_pf_checker (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchLen(fetchLen),
  .fetchGrant(fetchGrant), .burstActive(burstActive), .blanked(blanked),
  .frameSync(frameSync), .pixPop(pixPop), .pixValid(pixValid),
  .underrunFlag(underrunFlag), .underrunClr(underrunClr), .fillCount(fillCount)
);

// File: tb/test_pixel_prefetch_fifo.sv
module test_pixel_prefetch_fifo;
  localparam int DEPTH = 32;
  localparam int WIDTH = 32;
  localparam int CW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [CW-1:0] lowMark, highMark;
  logic dynBurst;
  logic fetchReq;
  logic [CW-1:0] fetchLen;
  logic fetchGrant, fillValid;
  logic [WIDTH-1:0] fillData;
  logic pixPop, pixValid;
  logic [WIDTH-1:0] pixData;
  logic frameSync, underrunClr, underrunFlag;

  pixel_prefetch_fifo i_pixel_prefetch_fifo (
    .clk(clk), .rstN(rstN), .lowMark(lowMark), .highMark(highMark),
    .dynBurst(dynBurst), .fetchReq(fetchReq), .fetchLen(fetchLen),
    .fetchGrant(fetchGrant), .fillValid(fillValid), .fillData(fillData),
    .pixPop(pixPop), .pixValid(pixValid), .pixData(pixData),
    .frameSync(frameSync), .underrunClr(underrunClr), .underrunFlag(underrunFlag)
  );

  int nRun = 0, nFail = 0;
  logic [WIDTH-1:0] q[$];
  bit mBlank, mFlag, prevReq, streaming, holdGrant, exactDrain, sawRise;
  int preSize, remainWords, grantedLen;
  logic [WIDTH-1:0] nextWord;
  string segTag;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int expLen(input int cnt);
    int tgt;
    if (dynBurst) begin
      tgt = (highMark < 2) ? DEPTH : DEPTH + 2 - int'(highMark);
      return (tgt > cnt) ? tgt - cnt : 0;
    end
    return int'(highMark);
  endfunction

  task automatic doReset(input bit dyn, input int hi, input int lo);
    rstN = 1'b0; fetchGrant = 0; fillValid = 0; fillData = '0;
    pixPop = 0; frameSync = 0; underrunClr = 0;
    dynBurst = dyn; highMark = CW'(hi); lowMark = CW'(lo);
    q.delete(); mBlank = 0; mFlag = 0; prevReq = 0; streaming = 0;
    remainWords = 0; holdGrant = 0; exactDrain = 0; preSize = 0;
    repeat (3) @(negedge clk);
    check(fetchReq == 0 && pixValid == 0 && underrunFlag == 0, "R1",
          "reset outputs", {fetchReq, pixValid, underrunFlag}, 0);
    rstN = 1'b1;
  endtask

  // One clock: drive at negedge, update model after posedge, compare at next negedge.
  task automatic cycle(input bit pop, input bit sync, input bit clr);
    int sz;
    bit underEv, doPop, doPush, flush;
    fetchGrant = 0; fillValid = 0;
    if (streaming && remainWords > 0 && $urandom_range(3) != 0) begin
      fillValid = 1; fillData = nextWord;
    end else if (!streaming && fetchReq && !holdGrant && $urandom_range(1) == 0) begin
      fetchGrant = 1; grantedLen = int'(fetchLen);
    end
    pixPop = pop; frameSync = sync; underrunClr = clr;
    @(posedge clk); #1;
    sz = q.size(); preSize = sz;
    underEv = pop && sz == 0;
    doPop = pop && sz != 0 && !mBlank;
    flush = sync && mBlank;
    doPush = fillValid && sz < DEPTH && !flush;
    if (flush) q.delete();
    else begin
      if (doPop) void'(q.pop_front());
      if (doPush) q.push_back(fillData);
    end
    if (underEv) mBlank = 1; else if (flush) mBlank = 0;
    if (underEv) mFlag = 1; else if (clr) mFlag = 0;
    if (fetchGrant) begin streaming = 1; remainWords = grantedLen; end
    if (fillValid) begin
      nextWord++; remainWords--;
      if (remainWords == 0) streaming = 0;
    end
    @(negedge clk);
    check(pixValid == (q.size() != 0 && !mBlank), {segTag, " R6 R8"}, "pixValid",
          pixValid, q.size() != 0 && !mBlank);
    if (q.size() != 0 && !mBlank)
      check(pixData == q[0], {segTag, " R6"}, "pixData", pixData, q[0]);
    else
      check(pixData == 0, {segTag, " R6"}, "pixData idle", pixData, 0);
    check(underrunFlag == mFlag, {segTag, " R7"}, "underrunFlag", underrunFlag, mFlag);
    if (fetchReq && !prevReq) begin
      sawRise = 1;
      check(preSize <= int'(lowMark), "R2", "count at request", preSize, lowMark);
      if (exactDrain)
        check(preSize == int'(lowMark), "R2", "exact trigger count", preSize, lowMark);
      check(int'(fetchLen) == expLen(preSize), dynBurst ? "R5" : "R4", "fetchLen",
            fetchLen, expLen(preSize));
    end
    if (streaming) check(!fetchReq, "R3", "request during burst", fetchReq, 0);
    if (prevReq && !streaming && !fetchGrant_seen())
      check(fetchReq, "R3", "request dropped before grant", fetchReq, 1);
    prevReq = fetchReq;
  endtask

  function automatic bit fetchGrant_seen();
    return fetchGrant;
  endfunction

  task automatic runRandom(input int n, input int popPct, input int syncPct, input int clrPct);
    for (int i = 0; i < n; i++)
      cycle($urandom_range(99) < popPct, $urandom_range(999) < syncPct * 10,
            $urandom_range(99) < clrPct);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] held;
    void'($urandom(32'd20240));
    nextWord = 32'hA000_0000;

    // Dynamic 4/8: quiet fill, then steady drain to the exact trigger.
    segTag = "R5";
    doReset(1'b1, 4, 8);
    repeat (60) cycle(0, 0, 0);
    check(q.size() == 30 && pixValid, "R5", "stored after quiet fill", q.size(), 30);
    exactDrain = 1; sawRise = 0;
    for (int i = 0; i < 40 && !sawRise; i++) cycle(1, 0, 0);
    check(sawRise, "R2", "request seen while draining", sawRise, 1);
    exactDrain = 0;
    repeat (60) cycle(0, 0, 0);

    // Fixed 8/12 under random pops.
    segTag = "R4";
    doReset(1'b0, 8, 12);
    runRandom(800, 40, 0, 0);

    // Dynamic 6/10 under random pops.
    segTag = "R5";
    doReset(1'b1, 6, 10);
    runRandom(800, 55, 0, 0);

    // Overflow: fixed burst longer than the free space, then no more grants.
    segTag = "R10";
    doReset(1'b0, 20, 20);
    repeat (120) cycle(0, 0, 0);
    holdGrant = 1;
    repeat (20) cycle(0, 0, 0);
    for (int i = 0; i < 31; i++) cycle(1, 0, 0);
    check(pixValid == 1, "R10", "valid before last stored word", pixValid, 1);
    cycle(1, 0, 0);
    check(pixValid == 0, "R10", "empty after exactly 32 pops", pixValid, 0);
    check(underrunFlag == 0, "R10", "no underrun from 32 pops", underrunFlag, 0);

    // Hold request without grant.
    repeat (10) cycle(0, 0, 0);
    check(fetchReq == 1, "R3", "request held while ungranted", fetchReq, 1);

    // Directed frame sync, underrun, flush and clear.
    segTag = "R8";
    doReset(1'b1, 4, 8);
    repeat (60) cycle(0, 0, 0);
    holdGrant = 1;
    held = pixData;
    cycle(0, 1, 0);
    check(pixValid == 1 && pixData == held, "R9", "sync without underrun", pixData, held);
    for (int i = 0; i < 30; i++) cycle(1, 0, 0);
    cycle(1, 0, 0);
    check(underrunFlag == 1, "R7", "flag after empty pop", underrunFlag, 1);
    holdGrant = 0;
    repeat (60) cycle(0, 0, 0);
    check(pixValid == 0, "R8", "blank while words stored", pixValid, 0);
    repeat (3) cycle(1, 0, 0);
    check(pixValid == 0, "R8", "pops ignored while blank", pixValid, 0);
    holdGrant = 1;
    repeat (10) cycle(0, 0, 0);
    cycle(0, 1, 0);
    check(pixValid == 0 && q.size() == 0, "R8", "flush at frame sync", pixValid, 0);
    cycle(0, 0, 1);
    check(underrunFlag == 0, "R7", "flag cleared", underrunFlag, 0);
    holdGrant = 0;
    repeat (60) cycle(0, 0, 0);
    check(pixValid == 1, "R8", "output recovers after flush", pixValid, 1);

    // Random underrun stress in both modes.
    segTag = "R7 R8";
    doReset(1'b1, 4, 8);
    runRandom(1500, 90, 2, 3);
    doReset(1'b0, 6, 6);
    runRandom(1500, 85, 2, 3);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule